// File: doc/BRIEF.md
# Shared-Cache Event Counter Block

This block counts traffic events inside a shared cache on behalf of profiling software. It holds a bank of wide counters. Each counter is pointed at one of several hundred event strobes by an 8-bit selector code. A counter advances by one in every cycle where its selected strobe is high, counting is switched on globally and for that counter, and every filter that is switched on accepts the request attributes that travel with the strobes in that cycle.

Software reaches everything through a plain 32-bit register port. A read returns its data one cycle later. Each 64-bit counter occupies two word addresses. Reading the low word captures the upper half, so a following read of the high word returns a consistent pair. When a counter wraps, it raises a sticky status bit. Status bits are cleared by writing ones, and each can be masked before it drives the shared interrupt line.

Three filters can be chained. The first passes read requests only. The second passes one source identifier, and it acts only while the read filter is active. The third passes one ring channel, and it applies only to a fixed window of event codes.

Top module: `ucache_pmu`

## Requirements
- R1: After reset, every counter reads 0, the interrupt mask (0x800) reads 0xFF, the status register (0x808) reads 0, the event control register (0x1C00) reads 0, `irq` is low, and the identification word at 0x1CF0 reads the VERSION parameter.
- R2: Counter i advances by exactly one per cycle only when its strobe is high, the global run bit (bit 26 of 0x1C00) is set and the counter's enable (bit i of 0x1C00) is set. If either bit is clear, the counter holds its value.
- R3: The selector code of counter i is the byte at bit (i mod 4)*8 of the selector word at 0x1D00 + 4*(i/4). The counter follows the strobe whose index equals that code.
- R4: Counter i is reached at 0x1E00 + 8*i (bits 31:0) and 0x1E00 + 8*i + 4 (bits 63:32). A write loads only the addressed half. A low-word read captures the upper half, and a high-word read returns the half captured by the most recent low-word read, even if the counter has changed since.
- R5: When a counter advances from all ones to zero, its bit in the status register 0x808 becomes 1, and the counter continues from zero.
- R6: Writing to 0x80C clears exactly the status bits written as 1. Status bits written as 0 keep their value.
- R7: `irq` is high exactly when some status bit is set whose mask bit (0x800, 1 = masked) is 0.
- R8: Read filtering is active while the filter master bit (bit 29 of 0x1C00) is set, the request-filter enable (bit 2 of 0x1B2C) is set and the request-type field (bits 9:7 of 0x1B2C) equals 4. While it is active, only cycles with `req_is_read` high count.
- R9: Source filtering (bit 3 of 0x1B2C) takes effect only while read filtering is active. It then requires `req_srcid` to equal bits 14:1 of 0x1B40. With read filtering inactive, bit 3 has no effect.
- R10: A nonzero channel field (bits 28:27 of 0x1C00) makes counters with codes 0x47 to 0x59 count only when `req_chan` equals the field. Counters with other codes are unaffected. A field value of 0 disables channel filtering.
- R11: `bus_rdata` presents the addressed register one cycle after `bus_rd`. The control registers return their stored fields: selector words in full, 0x1B2C bits 9:7, 3, 2 and 0, 0x1B40 bits 14:1, and 0x1C00 bits 29:26 and 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| evt_pulse | input | 256 | Event strobes, one per event code |
| req_is_read | input | 1 | The request behind this cycle's strobes is a read |
| req_srcid | input | 14 | Source identifier of this cycle's request |
| req_chan | input | 2 | Ring channel of this cycle's request |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest condition to reach from the ports is a 64-bit wrap: counting up from zero would never get there. The stimulus preloads the counter with all ones through two word writes and then applies a single strobe. It then checks the zero value, the raised status bit and the masked, unmasked and cleared states of the interrupt. The captured high word is exercised in a similar way. A carry from the low half is forced by preloading, and the high half is then rewritten between the two reads to show that the returned value is the one captured earlier.

// File: rtl/ucpmu_pkg.sv
`timescale 1ns/1ps
package ucpmu_pkg;
  localparam int ADDR_W = 16;
  localparam int SRC_W  = 14;
  localparam int CH_W   = 2;

  localparam logic [ADDR_W-1:0] A_IMASK = 16'h0800;
  localparam logic [ADDR_W-1:0] A_ISTS  = 16'h0808;
  localparam logic [ADDR_W-1:0] A_ICLR  = 16'h080C;
  localparam logic [ADDR_W-1:0] A_TTCTL = 16'h1B2C;
  localparam logic [ADDR_W-1:0] A_SRCID = 16'h1B40;
  localparam logic [ADDR_W-1:0] A_EVCTL = 16'h1C00;
  localparam logic [ADDR_W-1:0] A_VER   = 16'h1CF0;
  localparam logic [ADDR_W-1:0] A_EVSEL = 16'h1D00;
  localparam logic [ADDR_W-1:0] A_CNT   = 16'h1E00;

  // event control fields
  localparam int GLB_BIT = 26;
  localparam int CH_LO   = 27;
  localparam int TT_BIT  = 29;
  // request filter control fields
  localparam int MARK_BIT  = 0;
  localparam int RQEN_BIT  = 2;
  localparam int SRCEN_BIT = 3;
  localparam int RQSEL_LO  = 7;
  localparam logic [2:0] RQSEL_READ = 3'd4;
  // code window subject to channel filtering
  localparam logic [7:0] RING_LO = 8'h47;
  localparam logic [7:0] RING_HI = 8'h59;

  typedef struct packed {
    logic             rd_on;
    logic             src_on;
    logic [CH_W-1:0]  chan;
    logic [SRC_W-1:0] srcid;
  } filt_cfg_t;
endpackage

// File: rtl/ucpmu_filter.sv
`timescale 1ns/1ps
module ucpmu_filter
  import ucpmu_pkg::*;
#(
  parameter int NUM_EVT = 256,
  parameter int EVT_W   = 8
) (
  input  logic [EVT_W-1:0]   code,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  filt_cfg_t          cfg,
  input  logic               req_is_read,
  input  logic [SRC_W-1:0]   req_srcid,
  input  logic [CH_W-1:0]    req_chan,
  output logic               hit
);
  logic strobe, in_ring, rd_ok, src_ok, ch_ok;

  always_comb begin
    strobe  = evt_pulse[code];
    in_ring = (code >= EVT_W'(RING_LO)) && (code <= EVT_W'(RING_HI));
    rd_ok   = !cfg.rd_on || req_is_read;
    src_ok  = !cfg.src_on || (req_srcid == cfg.srcid);
    ch_ok   = (cfg.chan == '0) || !in_ring || (req_chan == cfg.chan);
    hit     = strobe && rd_ok && src_ok && ch_ok;
  end
endmodule

// File: rtl/ucpmu_counter.sv
`timescale 1ns/1ps
module ucpmu_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [31:0]  wdata,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam int HI_W = W - 32;

  logic [W-1:0] val_q, val_d;
  logic         load;

  always_comb begin
    val_d = val_q;
    wrap  = 1'b0;
    load  = wr_lo || wr_hi || inc;
    if (wr_lo) begin
      val_d[31:0] = wdata;
    end else if (wr_hi) begin
      val_d[W-1:32] = wdata[HI_W-1:0];
    end else if (inc) begin
      val_d = val_q + 1'b1;
      wrap  = &val_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val_q <= '0;
    else if (load) val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/ucache_pmu.sv
`timescale 1ns/1ps
module ucache_pmu
  import ucpmu_pkg::*;
#(
  parameter int          NUM_CNTR = 8,
  parameter int          CNT_W    = 64,
  parameter int          NUM_EVT  = 256,
  parameter int          EVT_W    = 8,
  parameter logic [31:0] VERSION  = 32'h0000_0102
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               req_is_read,
  input  logic [SRC_W-1:0]   req_srcid,
  input  logic [CH_W-1:0]    req_chan,
  output logic               irq
);
  localparam int PER_WORD = 32 / EVT_W;
  localparam int NUM_SEL  = (NUM_CNTR + PER_WORD - 1) / PER_WORD;
  localparam int IDX_W    = (NUM_CNTR > 1) ? $clog2(NUM_CNTR) : 1;
  localparam int SEL_W    = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
  localparam int HI_W     = CNT_W - 32;

  // reset: asserted asynchronously, released on clock
  logic rst_s1, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  // state
  logic [NUM_CNTR-1:0] cnt_en_q, cnt_en_d, mask_q, mask_d, sts_q, sts_d;
  logic                glb_q, glb_d, tten_q, tten_d;
  logic [CH_W-1:0]     chan_q, chan_d;
  logic [2:0]          rqsel_q, rqsel_d;
  logic                mark_q, mark_d, rqen_q, rqen_d, srcen_q, srcen_d;
  logic [SRC_W-1:0]    srcid_q, srcid_d;
  logic [EVT_W-1:0]    code_q [NUM_CNTR];
  logic [EVT_W-1:0]    code_d [NUM_CNTR];
  logic [HI_W-1:0]     hi_lat_q, hi_lat_d;
  logic [31:0]         rdata_q, rdata_d, rd_val;

  logic [CNT_W-1:0]    cnt_val [NUM_CNTR];
  logic [NUM_CNTR-1:0] inc_vec, hit_vec, wrap_vec;

  // decode
  logic             cnt_reg, sel_reg, hi_half;
  logic [IDX_W-1:0] cnt_idx;
  logic [SEL_W-1:0] sel_idx;
  always_comb begin
    cnt_reg = (bus_addr >= A_CNT) && (bus_addr < A_CNT + ADDR_W'(NUM_CNTR * 8));
    sel_reg = (bus_addr >= A_EVSEL) && (bus_addr < A_EVSEL + ADDR_W'(NUM_SEL * 4));
    cnt_idx = bus_addr[IDX_W+2:3];
    sel_idx = bus_addr[SEL_W+1:2];
    hi_half = bus_addr[2];
  end

  // next state of control registers
  always_comb begin
    cnt_en_d = cnt_en_q;
    glb_d    = glb_q;
    chan_d   = chan_q;
    tten_d   = tten_q;
    mask_d   = mask_q;
    rqsel_d  = rqsel_q;
    mark_d   = mark_q;
    rqen_d   = rqen_q;
    srcen_d  = srcen_q;
    srcid_d  = srcid_q;
    code_d   = code_q;
    sts_d    = sts_q;
    if (bus_wr) begin
      if (bus_addr == A_EVCTL) begin
        cnt_en_d = bus_wdata[NUM_CNTR-1:0];
        glb_d    = bus_wdata[GLB_BIT];
        chan_d   = bus_wdata[CH_LO +: CH_W];
        tten_d   = bus_wdata[TT_BIT];
      end
      if (bus_addr == A_IMASK) mask_d = bus_wdata[NUM_CNTR-1:0];
      if (bus_addr == A_TTCTL) begin
        rqsel_d = bus_wdata[RQSEL_LO +: 3];
        mark_d  = bus_wdata[MARK_BIT];
        rqen_d  = bus_wdata[RQEN_BIT];
        srcen_d = bus_wdata[SRCEN_BIT];
      end
      if (bus_addr == A_SRCID) srcid_d = bus_wdata[1 +: SRC_W];
      if (bus_addr == A_ICLR)  sts_d = sts_q & ~bus_wdata[NUM_CNTR-1:0];
      if (sel_reg) begin
        for (int k = 0; k < NUM_CNTR; k++) begin
          if (k / PER_WORD == int'(sel_idx))
            code_d[k] = bus_wdata[(k % PER_WORD) * EVT_W +: EVT_W];
        end
      end
    end
    sts_d = sts_d | wrap_vec;
  end

  // read path
  always_comb begin
    rd_val = '0;
    if (bus_addr == A_IMASK) rd_val[NUM_CNTR-1:0] = mask_q;
    if (bus_addr == A_ISTS)  rd_val[NUM_CNTR-1:0] = sts_q;
    if (bus_addr == A_VER)   rd_val = VERSION;
    if (bus_addr == A_SRCID) rd_val[1 +: SRC_W] = srcid_q;
    if (bus_addr == A_TTCTL) begin
      rd_val[RQSEL_LO +: 3] = rqsel_q;
      rd_val[MARK_BIT]      = mark_q;
      rd_val[RQEN_BIT]      = rqen_q;
      rd_val[SRCEN_BIT]     = srcen_q;
    end
    if (bus_addr == A_EVCTL) begin
      rd_val[NUM_CNTR-1:0]    = cnt_en_q;
      rd_val[GLB_BIT]         = glb_q;
      rd_val[CH_LO +: CH_W]   = chan_q;
      rd_val[TT_BIT]          = tten_q;
    end
    if (sel_reg) begin
      for (int k = 0; k < NUM_CNTR; k++) begin
        if (k / PER_WORD == int'(sel_idx))
          rd_val[(k % PER_WORD) * EVT_W +: EVT_W] = code_q[k];
      end
    end
    if (cnt_reg) rd_val = hi_half ? 32'(hi_lat_q) : cnt_val[cnt_idx][31:0];
    rdata_d  = bus_rd ? rd_val : rdata_q;
    hi_lat_d = (bus_rd && cnt_reg && !hi_half) ? cnt_val[cnt_idx][CNT_W-1:32] : hi_lat_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_en_q <= '0;
      glb_q    <= 1'b0;
      chan_q   <= '0;
      tten_q   <= 1'b0;
      mask_q   <= '1;
      sts_q    <= '0;
      rqsel_q  <= '0;
      mark_q   <= 1'b0;
      rqen_q   <= 1'b0;
      srcen_q  <= 1'b0;
      srcid_q  <= '0;
      hi_lat_q <= '0;
      rdata_q  <= '0;
      for (int k = 0; k < NUM_CNTR; k++) code_q[k] <= '0;
    end else begin
      cnt_en_q <= cnt_en_d;
      glb_q    <= glb_d;
      chan_q   <= chan_d;
      tten_q   <= tten_d;
      mask_q   <= mask_d;
      sts_q    <= sts_d;
      rqsel_q  <= rqsel_d;
      mark_q   <= mark_d;
      rqen_q   <= rqen_d;
      srcen_q  <= srcen_d;
      srcid_q  <= srcid_d;
      hi_lat_q <= hi_lat_d;
      rdata_q  <= rdata_d;
      code_q   <= code_d;
    end
  end

  // filter configuration shared by all counter slices
  filt_cfg_t cfg;
  always_comb begin
    cfg.rd_on  = tten_q && rqen_q && (rqsel_q == RQSEL_READ);
    cfg.src_on = cfg.rd_on && srcen_q;
    cfg.chan   = chan_q;
    cfg.srcid  = srcid_q;
  end

  logic cnt_wr;
  assign cnt_wr = bus_wr && cnt_reg;

  for (genvar g = 0; g < NUM_CNTR; g++) begin : g_slice
    ucpmu_filter #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u_filt (
      .code        (code_q[g]),
      .evt_pulse   (evt_pulse),
      .cfg         (cfg),
      .req_is_read (req_is_read),
      .req_srcid   (req_srcid),
      .req_chan    (req_chan),
      .hit         (hit_vec[g])
    );
    assign inc_vec[g] = hit_vec[g] && glb_q && cnt_en_q[g];
    ucpmu_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_q_n),
      .inc   (inc_vec[g]),
      .wr_lo (cnt_wr && (cnt_idx == IDX_W'(g)) && !hi_half),
      .wr_hi (cnt_wr && (cnt_idx == IDX_W'(g)) && hi_half),
      .wdata (bus_wdata),
      .value (cnt_val[g]),
      .wrap  (wrap_vec[g])
    );
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(sts_q & ~mask_q);
endmodule

// File: rtl/ucpmu_checker.sv
`timescale 1ns/1ps
module ucpmu_checker
  import ucpmu_pkg::*;
#(
  parameter int NUM_CNTR = 8,
  parameter int CNT_W    = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                clr_b0,
  input logic                glb_en,
  input logic [CNT_W-1:0]    cnt0,
  input logic [NUM_CNTR-1:0] sts,
  input logic [NUM_CNTR-1:0] mask,
  input logic                irq
);
  logic cnt_wr, clr0;
  assign cnt_wr = bus_wr && (bus_addr >= A_CNT) && (bus_addr < A_CNT + ADDR_W'(NUM_CNTR * 8));
  assign clr0   = bus_wr && (bus_addr == A_ICLR) && clr_b0;

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cnt_wr) |=> $stable(cnt0));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) + 1'b1));

  p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt0) && !cnt_wr) |=> ((&cnt0) || (cnt0 == '0 && sts[0])));

  p_sticky_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !clr0) |=> sts[0]);

  p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != '0));
endmodule

bind ucache_pmu ucpmu_checker #(.NUM_CNTR(NUM_CNTR), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .clr_b0   (bus_wdata[0]),
  .glb_en   (glb_q),
  .cnt0     (cnt_val[0]),
  .sts      (sts_q),
  .mask     (mask_q),
  .irq      (irq)
);

// File: tb/ucache_pmu_test.sv
`timescale 1ns/1ps
module ucache_pmu_test;
  import ucpmu_pkg::*;

  localparam logic [31:0] VER = 32'h0000_0102;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] evt_pulse = '0;
  logic         req_is_read = 1'b0;
  logic [13:0]  req_srcid = '0;
  logic [1:0]   req_chan = '0;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ucache_pmu #(.VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .req_is_read(req_is_read), .req_srcid(req_srcid),
    .req_chan(req_chan), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_cnt(input int i, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(A_CNT + 16'(8 * i), lo);
    rd(A_CNT + 16'(8 * i + 4), hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input int i, input logic [63:0] v);
    wr(A_CNT + 16'(8 * i), v[31:0]);
    wr(A_CNT + 16'(8 * i + 4), v[63:32]);
  endtask

  function automatic logic [31:0] evctl(input logic [7:0] en, input logic glb,
                                        input logic [1:0] ch, input logic tt);
    return {2'b0, tt, ch, glb, 18'b0, en};
  endfunction

  task automatic pulse(input int a, input int b, input int n, input logic rdq,
                       input logic [13:0] src, input logic [1:0] ch);
    @(negedge clk);
    evt_pulse = '0;
    if (a >= 0) evt_pulse[a] = 1'b1;
    if (b >= 0) evt_pulse[b] = 1'b1;
    req_is_read = rdq; req_srcid = src; req_chan = ch;
    repeat (n) @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic [63:0] v;
    rd_cnt(0, v);      check("R1 counter0", v, 64'd0);
    rd_cnt(7, v);      check("R1 counter7", v, 64'd0);
    rd(A_IMASK, d);    check("R1 mask", 64'(d), 64'hFF);
    rd(A_ISTS, d);     check("R1 status", 64'(d), 64'h0);
    rd(A_EVCTL, d);    check("R1 evctl", 64'(d), 64'h0);
    rd(A_VER, d);      check("R1 version", 64'(d), 64'(VER));
    check("R1 irq", 64'(irq), 64'd0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    logic [63:0] v;
    wr(A_EVSEL, 32'h3010_2010);
    wr(A_EVSEL + 16'd4, 32'h4760_5040);
    wr(A_EVCTL, evctl(8'h03, 1'b1, 2'd0, 1'b0));
    rd(A_EVCTL, d);         check("R11 evctl readback", 64'(d), 64'h0400_0003);
    rd(A_EVSEL, d);         check("R11 selector readback", 64'(d), 64'h3010_2010);
    pulse(8'h10, -1, 5, 1'b0, 14'd0, 2'd0);
    pulse(8'h20, -1, 3, 1'b0, 14'd0, 2'd0);
    pulse(8'h10, 8'h20, 1, 1'b0, 14'd0, 2'd0);
    rd_cnt(0, v); check("R2 R3 counter0 code 0x10", v, 64'd6);
    rd_cnt(1, v); check("R3 counter1 code 0x20", v, 64'd4);
    rd_cnt(2, v); check("R2 counter2 disabled", v, 64'd0);
  endtask

  task automatic t_gating;
    logic [63:0] v;
    wr(A_EVCTL, evctl(8'h03, 1'b0, 2'd0, 1'b0));
    pulse(8'h10, -1, 4, 1'b0, 14'd0, 2'd0);
    rd_cnt(0, v); check("R2 global off holds", v, 64'd6);
    wr(A_EVCTL, evctl(8'h02, 1'b1, 2'd0, 1'b0));
    pulse(8'h10, -1, 2, 1'b0, 14'd0, 2'd0);
    rd_cnt(0, v); check("R2 counter enable off holds", v, 64'd6);
  endtask

  task automatic t_wide;
    logic [31:0] d;
    set_cnt(3, 64'h0000_0012_FFFF_FFFE);
    wr(A_EVCTL, evctl(8'h08, 1'b1, 2'd0, 1'b0));
    pulse(8'h30, -1, 2, 1'b0, 14'd0, 2'd0);
    rd(A_CNT + 16'd24, d); check("R4 low after carry", 64'(d), 64'h0);
    rd(A_CNT + 16'd28, d); check("R4 high after carry", 64'(d), 64'h13);
    wr(A_CNT + 16'd28, 32'h55);
    rd(A_CNT + 16'd28, d); check("R4 high from earlier capture", 64'(d), 64'h13);
    rd(A_CNT + 16'd24, d);
    rd(A_CNT + 16'd28, d); check("R4 high after new capture", 64'(d), 64'h55);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    logic [63:0] v;
    set_cnt(4, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_EVCTL, evctl(8'h10, 1'b1, 2'd0, 1'b0));
    rd(A_ISTS, d); check("R5 status before wrap", 64'(d), 64'h0);
    pulse(8'h40, -1, 1, 1'b0, 14'd0, 2'd0);
    rd_cnt(4, v);  check("R5 counter wrapped to zero", v, 64'd0);
    rd(A_ISTS, d); check("R5 status bit4 set", 64'(d), 64'h10);
    check("R7 irq masked", 64'(irq), 64'd0);
    wr(A_IMASK, 32'hEF);
    @(negedge clk); check("R7 irq unmasked", 64'(irq), 64'd1);
    wr(A_ICLR, 32'h01);
    rd(A_ISTS, d); check("R6 other bit kept", 64'(d), 64'h10);
    wr(A_ICLR, 32'h10);
    rd(A_ISTS, d); check("R6 bit cleared", 64'(d), 64'h0);
    check("R7 irq after clear", 64'(irq), 64'd0);
  endtask

  task automatic t_read_filter;
    logic [31:0] d;
    logic [63:0] v;
    wr(A_EVCTL, evctl(8'h20, 1'b1, 2'd0, 1'b1));
    wr(A_TTCTL, 32'h205);
    rd(A_TTCTL, d); check("R11 filter control readback", 64'(d), 64'h205);
    pulse(8'h50, -1, 3, 1'b1, 14'd0, 2'd0);
    pulse(8'h50, -1, 2, 1'b0, 14'd0, 2'd0);
    rd_cnt(5, v); check("R8 reads only", v, 64'd3);
    wr(A_TTCTL, 32'h105);
    pulse(8'h50, -1, 2, 1'b0, 14'd0, 2'd0);
    rd_cnt(5, v); check("R8 other request type no filter", v, 64'd5);
    wr(A_TTCTL, 32'h205);
    wr(A_EVCTL, evctl(8'h20, 1'b1, 2'd0, 1'b0));
    pulse(8'h50, -1, 1, 1'b0, 14'd0, 2'd0);
    rd_cnt(5, v); check("R8 master bit off no filter", v, 64'd6);
  endtask

  task automatic t_src_filter;
    logic [31:0] d;
    logic [63:0] v;
    wr(A_SRCID, 32'h2468);
    rd(A_SRCID, d); check("R11 source id readback", 64'(d), 64'h2468);
    wr(A_EVCTL, evctl(8'h40, 1'b1, 2'd0, 1'b1));
    wr(A_TTCTL, 32'h20D);
    pulse(8'h60, -1, 2, 1'b1, 14'h1234, 2'd0);
    pulse(8'h60, -1, 3, 1'b1, 14'h0111, 2'd0);
    pulse(8'h60, -1, 1, 1'b0, 14'h1234, 2'd0);
    rd_cnt(6, v); check("R9 matching reads only", v, 64'd2);
    wr(A_TTCTL, 32'h008);
    pulse(8'h60, -1, 2, 1'b0, 14'h0111, 2'd0);
    rd_cnt(6, v); check("R9 source bit alone ignored", v, 64'd4);
  endtask

  task automatic t_ring;
    logic [63:0] v;
    wr(A_TTCTL, 32'h0);
    set_cnt(6, 64'd0);
    set_cnt(7, 64'd0);
    wr(A_EVSEL + 16'd4, 32'h475A_5040);
    wr(A_EVCTL, evctl(8'hC0, 1'b1, 2'd2, 1'b0));
    pulse(8'h47, 8'h5A, 2, 1'b0, 14'd0, 2'd2);
    pulse(8'h47, 8'h5A, 3, 1'b0, 14'd0, 2'd1);
    rd_cnt(7, v); check("R10 code 0x47 channel filtered", v, 64'd2);
    rd_cnt(6, v); check("R10 code 0x5A unaffected", v, 64'd5);
    wr(A_EVSEL + 16'd4, 32'h595A_5040);
    pulse(8'h59, -1, 1, 1'b0, 14'd0, 2'd3);
    rd_cnt(7, v); check("R10 code 0x59 wrong channel", v, 64'd2);
    wr(A_EVCTL, evctl(8'hC0, 1'b1, 2'd0, 1'b0));
    pulse(8'h59, -1, 1, 1'b0, 14'd0, 2'd3);
    rd_cnt(7, v); check("R10 channel field zero", v, 64'd3);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_gating();
    t_wide();
    t_wrap();
    t_read_filter();
    t_src_filter();
    t_ring();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end
endmodule